// File: doc/BRIEF.md
# Device interrupt route register bank

This block holds a small byte-addressed register window that decides, for every device slot on a PCI bus, which of eight shared interrupt request lines (index 0 to 7, lines A to H) each of the slot's four interrupt pins (INTA to INTD) drives. Seven 16-bit route registers cover device numbers 25 to 31. Each register holds one 4-bit field per pin, and the low three bits of the field give the line index. The route register of device 30 reads as zero and cannot be written: that slot's pins always land on lines E to H. Every other slot uses a fixed rotated mapping that only touches lines E to H.

Software reaches the window through a single access port: an address, a byte length from 0 to 4, and little-endian data. The address is reduced to the window size. An access that would run past the last byte is shortened so that it stops at the window end. Every accepted write produces a one-cycle routing-changed pulse, so that interrupt routing consumers can re-read their mappings. A combinational lookup port turns a slot number and a pin number into a line index.

Top module: `intr_route_bank`

## Requirements
- R1: After reset, every window byte is zero except the route registers, which hold 16'h3210 for each device other than 30, and the 32-bit general control word at byte offset 16, which holds 32'h0000_0001.
- R2: The route register of device 25+k sits at byte offset 2k as a little-endian 16-bit value. The field for pin p (0 = INTA to 3 = INTD) occupies bits 4p+3 to 4p, and its bits 4p+2 to 4p give the line index.
- R3: For slots 25 to 29 and 31, the lookup output follows the route field and shows a written value from the first cycle after the write clock edge.
- R4: Slot 30 always looks up to pin+4. Bytes 10 and 11 (its register) read as zero and are unchanged by writes.
- R5: Slots 0 to 24 look up to ((slot + pin) mod 4) + 4, whatever has been written.
- R6: Only the low 5 address bits select a byte, so the 32-byte window repeats through the address space.
- R7: An access whose address plus length exceeds 32 covers only the bytes up to offset 31. Nothing wraps to offset 0.
- R8: Data byte i maps to address+i. Read data lanes that are not accessed return zero, and read data is valid in the same cycle as the request.
- R9: route_changed is high for exactly the one cycle after each clock edge that accepts a write, including writes that change nothing, and it stays low after reads.
- R10: Window bytes that are not route registers are plain read/write storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access request |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 16 | Byte address, masked to the window |
| acc_len | input | 3 | Byte count, 0 to 4 |
| acc_wdata | input | 32 | Write data, little-endian |
| acc_rdata | output | 32 | Read data, combinational |
| route_changed | output | 1 | One-cycle pulse after each write |
| lk_slot | input | 5 | Lookup slot number |
| lk_pin | input | 2 | Lookup pin, 0 = INTA |
| lk_pirq | output | 3 | Shared line index 0 to 7 |

## Verification
Read data and lookup results are combinational. The bench therefore samples them 1 ns after driving the inputs on a falling edge, within the same cycle. Writes take effect at the next rising edge. The bench checks route_changed 1 ns after that edge and again one cycle later, where it must be low. Lookup sweeps over all 128 slot and pin pairs run only after the write edge, so every value they compare is already settled.

// File: rtl/intr_route_bank.sv
module intr_route_bank #(
  parameter int WIN_BYTES = 32,
  parameter int AW_IN = 16,
  parameter int SLOT_W = 5,
  parameter int FIRST_DEV = 25,
  parameter int NUM_ROUTE = 7,
  parameter int FIXED_DEV = 30,
  parameter int CTRL_OFS = 16,
  parameter logic [15:0] ROUTE_DEFAULT = 16'h3210,
  parameter logic [31:0] CTRL_DEFAULT = 32'h0000_0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [AW_IN-1:0]  acc_addr,
  input  logic [2:0]        acc_len,
  input  logic [31:0]       acc_wdata,
  output logic [31:0]       acc_rdata,
  output logic              route_changed,
  input  logic [SLOT_W-1:0] lk_slot,
  input  logic [1:0]        lk_pin,
  output logic [2:0]        lk_pirq
);
  localparam int ADDR_W = $clog2(WIN_BYTES);
  localparam int FIX_OFS = 2 * (FIXED_DEV - FIRST_DEV);
  localparam int ROUTE_END = 2 * NUM_ROUTE;

  logic [7:0] win [WIN_BYTES];
  logic [ADDR_W-1:0] base;
  logic [ADDR_W:0] room;
  logic [2:0] eff_len;
  logic [3:0] lane_on;
  logic [ADDR_W-1:0] lane_addr [4];

  assign base = acc_addr[ADDR_W-1:0];
  assign room = (ADDR_W+1)'(WIN_BYTES) - {1'b0, base};
  assign eff_len = ((ADDR_W+1)'(acc_len) > room) ? room[2:0] : acc_len;

  function automatic logic [7:0] reset_byte(input int b);
    if (b < ROUTE_END && b != FIX_OFS && b != FIX_OFS + 1)
      return ROUTE_DEFAULT[8*(b%2) +: 8];
    if (b >= CTRL_OFS && b < CTRL_OFS + 4)
      return CTRL_DEFAULT[8*(b-CTRL_OFS) +: 8];
    return 8'h00;
  endfunction

  function automatic logic is_fixed(input logic [ADDR_W-1:0] a);
    return (a == ADDR_W'(FIX_OFS)) || (a == ADDR_W'(FIX_OFS + 1));
  endfunction

  for (genvar i = 0; i < 4; i++) begin : g_lane
    assign lane_on[i] = 3'(i) < eff_len;
    assign lane_addr[i] = base + ADDR_W'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < WIN_BYTES; b++) win[b] <= reset_byte(b);
      route_changed <= 1'b0;
    end else begin
      route_changed <= acc_valid && acc_write;
      if (acc_valid && acc_write)
        for (int i = 0; i < 4; i++)
          if (lane_on[i] && !is_fixed(lane_addr[i]))
            win[lane_addr[i]] <= acc_wdata[8*i +: 8];
    end
  end

  always_comb begin
    acc_rdata = '0;
    if (acc_valid && !acc_write)
      for (int i = 0; i < 4; i++)
        if (lane_on[i]) acc_rdata[8*i +: 8] = win[lane_addr[i]];
  end

  logic [SLOT_W-1:0] rel;
  logic [7:0] rbyte;
  assign rel = lk_slot - SLOT_W'(FIRST_DEV);
  assign rbyte = win[ADDR_W'({rel, 1'b0}) + ADDR_W'(lk_pin[1])];

  always_comb begin
    if (lk_slot == SLOT_W'(FIXED_DEV))
      lk_pirq = {1'b1, lk_pin};
    else if (lk_slot >= SLOT_W'(FIRST_DEV) && rel < SLOT_W'(NUM_ROUTE))
      lk_pirq = lk_pin[0] ? rbyte[6:4] : rbyte[2:0];
    else
      lk_pirq = {1'b1, lk_slot[1:0] + lk_pin};
  end
endmodule

module intr_route_bank_chk #(
  parameter int AW_IN = 16,
  parameter int SLOT_W = 5,
  parameter int FIRST_DEV = 25,
  parameter int FIXED_DEV = 30
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              acc_write,
  input logic [AW_IN-1:0]  acc_addr,
  input logic [2:0]        acc_len,
  input logic [31:0]       acc_rdata,
  input logic              route_changed,
  input logic [SLOT_W-1:0] lk_slot,
  input logic [1:0]        lk_pin,
  input logic [2:0]        lk_pirq
);
  localparam logic [4:0] FIX_LO = 5'(2 * (FIXED_DEV - FIRST_DEV));

  assert_pulse_on_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write) |=> route_changed);
  assert_no_pulse_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && acc_write) |=> !route_changed);
  assert_fixed_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_slot == SLOT_W'(FIXED_DEV)) |-> (lk_pirq[2] && lk_pirq[1:0] == lk_pin));
  assert_fixed_reg_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && acc_len != 3'd0 &&
     (acc_addr[4:0] == FIX_LO || acc_addr[4:0] == FIX_LO + 5'd1)) |-> acc_rdata[7:0] == 8'h00);
  assert_low_slot_upper_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_slot < SLOT_W'(FIRST_DEV)) |-> lk_pirq[2]);
  assert_idle_lanes_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && acc_len == 3'd1) |-> acc_rdata[31:8] == 24'h0);
endmodule

bind intr_route_bank intr_route_bank_chk #(
  .AW_IN(AW_IN), .SLOT_W(SLOT_W), .FIRST_DEV(FIRST_DEV), .FIXED_DEV(FIXED_DEV)
) u_chk (.*);

// File: tb/intr_route_bank_tb.sv
module intr_route_bank_tb;
  logic clk = 0, rst_n = 0;
  logic acc_valid = 0, acc_write = 0;
  logic [15:0] acc_addr = 0;
  logic [2:0] acc_len = 0;
  logic [31:0] acc_wdata = 0, acc_rdata;
  logic route_changed;
  logic [4:0] lk_slot = 0;
  logic [1:0] lk_pin = 0;
  logic [2:0] lk_pirq;
  int n_chk = 0, n_bad = 0;
  logic [7:0] model [32];

  always #2 clk = ~clk;

  intr_route_bank u_dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int b = 0; b < 32; b++) model[b] = 8'h00;
    for (int k = 0; k < 7; k++) if (k != 5) begin model[2*k] = 8'h10; model[2*k+1] = 8'h32; end
    model[16] = 8'h01;
  endtask

  function automatic int clip(input int a, input int len);
    return (a + len > 32) ? 32 - a : len;
  endfunction

  task automatic do_write(input logic [15:0] a, input int len, input logic [31:0] d);
    int base = a[4:0];
    @(negedge clk);
    acc_valid = 1; acc_write = 1; acc_addr = a; acc_len = 3'(len); acc_wdata = d;
    @(posedge clk); #1;
    check("R9 pulse", {31'b0, route_changed}, 1);
    for (int i = 0; i < clip(base, len); i++)
      if (base + i != 10 && base + i != 11) model[base+i] = d[8*i +: 8];
    @(negedge clk);
    acc_valid = 0; acc_write = 0;
    @(posedge clk); #1;
    check("R9 single", {31'b0, route_changed}, 0);
  endtask

  task automatic do_read(input string req, input logic [15:0] a, input int len);
    int base = a[4:0];
    logic [31:0] exp = 0;
    for (int i = 0; i < clip(base, len); i++) exp[8*i +: 8] = model[base+i];
    @(negedge clk);
    acc_valid = 1; acc_write = 0; acc_addr = a; acc_len = 3'(len);
    #1 check(req, acc_rdata, exp);
    @(negedge clk);
    acc_valid = 0;
    @(posedge clk); #1;
    check("R9 read", {31'b0, route_changed}, 0);
  endtask

  function automatic logic [2:0] exp_pirq(input int s, input int p);
    if (s == 30) return 3'(p + 4);
    if (s >= 25) begin
      logic [7:0] b = model[2*(s-25) + p/2];
      return (p % 2) ? b[6:4] : b[2:0];
    end
    return 3'((s + p) % 4 + 4);
  endfunction

  task automatic sweep_lookup(input string req);
    for (int s = 0; s < 32; s++)
      for (int p = 0; p < 4; p++) begin
        @(negedge clk);
        lk_slot = 5'(s); lk_pin = 2'(p);
        #1 check(s == 30 ? "R4 lookup" : (s >= 25 ? req : "R5 lookup"), {29'b0, lk_pirq}, {29'b0, exp_pirq(s, p)});
      end
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(posedge clk); #1;
    check("R9 reset", {31'b0, route_changed}, 0);
    for (int b = 0; b < 32; b++) do_read("R1 reset image", 16'(b), 1);
    sweep_lookup("R2 default route");
    for (int k = 0; k < 7; k++) do_write(16'(2*k), 2, 32'hFFFF_0000 | 32'(16'h7654 + 16'(k*16'h1111)));
    sweep_lookup("R3 written route");
    do_write(16'd10, 2, 32'h0000_7777);
    do_read("R4 fixed reg", 16'd10, 2);
    do_write(16'd9, 4, 32'hA5A5_5A5A);
    do_read("R4 neighbour bytes", 16'd8, 4);
    sweep_lookup("R3 after partial");
    for (int a = 12; a < 32; a += 3)
      for (int l = 0; l <= 4; l++) begin
        do_write(16'(a), l, 32'h1020_3040 + 32'(a * 7 + l));
        do_read("R10 R8 storage", 16'(a), 4);
        do_read("R8 lanes", 16'(a), l);
      end
    do_write(16'hFF12, 2, 32'h0000_BEEF);
    do_read("R6 mask", 16'd18, 2);
    do_read("R6 alias read", 16'h4012, 2);
    do_write(16'd30, 4, 32'hDDCC_BBAA);
    do_read("R7 clip tail", 16'd30, 4);
    do_read("R7 no wrap", 16'd0, 2);
    sweep_lookup("R3 final");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule